// File: doc/BRIEF.md
# Cipher Length Countdown and Context Launch Control

This block is the control side of a block-cipher engine. It holds the payload byte count and the associated-data byte count for one cipher context. It launches the context when the host writes the register that the selected mode designates as the trigger. While the context runs, it counts both lengths down as the datapath consumes 16-byte blocks. A host port writes the lengths and reads a small status word. The datapath signals each consumed block on `blk_go`. The block drives the start and done pulses, the remaining counts, the byte count of the current block, and four status flags.

The payload count is 61 bits wide. It is assembled from a low word and the low 29 bits of a high word. There are three kinds of mode. In the plain modes, the high word launches the context, and a payload of zero means the stream has no end. In the authenticated modes, the associated-data length launches it. Either length may then be zero, but not both. In the tweaked mode, the associated-data register instead carries a 28-bit block index. The length registers are write-only and read back as zero.

Top module: `crypto_len_ctrl`

## Requirements
- R1: After reset the block is idle. `ctx_ready` is 1. `saved_ready`, `input_ready`, `output_ready`, `start`, `done` and both remaining counts are 0.
- R2: With `mode_sel` 0 or 3 (plain), a write to address 0 stores the low word without launching. A write to address 1 launches: `start` pulses one cycle after the write. `pay_rem` then becomes {wdata[28:0], low word}, and bits [31:29] of the high word are ignored.
- R3: With `mode_sel` 1 (authenticated), a write to address 1 only stores the high word. A write to address 2 launches with `auth_rem` equal to the written word and `pay_rem` equal to the stored 61-bit count.
- R4: In the authenticated mode, a launch write to address 2 whose value is zero is ignored if the stored payload count is also zero: no `start`, and `ctx_ready` stays 1.
- R5: Each accepted block subtracts 16 from the count being drained, saturating at zero. `cur_bytes` shows min(16, remaining) for that count.
- R6: In the authenticated mode, `auth_rem` drains fully before `pay_rem` decrements. `auth_phase` is 1 while `auth_rem` is nonzero.
- R7: The block that brings every count to zero makes `done` pulse one cycle. It also clears the running state.
- R8: In a plain mode, a launch with a zero payload count sets `endless`. `cur_bytes` is then 16, and `done` never pulses.
- R9: Host reads of addresses 0, 1 and 2 return zero. Address 3 returns {28'b0, ctx_ready, saved_ready, input_ready, output_ready}.
- R10: With `mode_sel` 2 (tweaked), a write to address 2 loads wdata[31:4] into `xts_j` and does not launch. Address 1 launches as in R2.
- R11: `ctx_ready` and `saved_ready` are never both 1. `saved_ready` rises only at a completion with `save_ctx_en` high, and `saved_ack` clears it.
- R12: A block is accepted only while `input_ready` is 1. An accepted block sets `output_ready` and clears `input_ready` until `out_ack`. A `blk_go` during that window has no effect.
- R13: Writes to addresses 0, 1 and 2 are ignored unless `ctx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 2 | 0/3 plain, 1 authenticated, 2 tweaked |
| save_ctx_en | input | 1 | Hold a saved result after completion |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| blk_go | input | 1 | Datapath consumed one block |
| out_ack | input | 1 | Output block taken |
| saved_ack | input | 1 | Saved result taken |
| start | output | 1 | Context launch pulse |
| done | output | 1 | Context completion pulse |
| pay_rem | output | 61 | Remaining payload bytes |
| auth_rem | output | 32 | Remaining associated-data bytes |
| cur_bytes | output | 5 | Valid bytes of current block |
| auth_phase | output | 1 | Associated data being drained |
| endless | output | 1 | Running without length limit |
| xts_j | output | 28 | Block index for tweaked mode |
| ctx_ready | output | 1 | Context registers may be rewritten |
| saved_ready | output | 1 | Saved result waiting |
| input_ready | output | 1 | Next block may be fed |
| output_ready | output | 1 | Result block waiting |

## Verification
On every cycle, the assertions check that the context and saved flags never overlap. They also check that a saved flag comes only from an enabled save, that the payload count never grows while running, and that a completion leaves both counts at zero. They further check that an endless stream never completes and that the input and output flags exclude each other. Other behaviours appear only in the bench's scenarios: which register launches in which mode, the exact count values after each block, the ordering of associated data before payload, the rejection of a doubly empty launch, the loading of the block index, and reads returning zero.

// File: rtl/crypto_len_ctrl.sv
module crypto_len_ctrl #(
  parameter int PAY_W     = 61,
  parameter int AUTH_W    = 32,
  parameter int BLK_BYTES = 16,
  parameter int J_W       = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              save_ctx_en,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [1:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              blk_go,
  input  logic              out_ack,
  input  logic              saved_ack,
  output logic              start,
  output logic              done,
  output logic [PAY_W-1:0]  pay_rem,
  output logic [AUTH_W-1:0] auth_rem,
  output logic [$clog2(BLK_BYTES):0] cur_bytes,
  output logic              auth_phase,
  output logic              endless,
  output logic [J_W-1:0]    xts_j,
  output logic              ctx_ready,
  output logic              saved_ready,
  output logic              input_ready,
  output logic              output_ready
);
  localparam int CNT_W = $clog2(BLK_BYTES) + 1;
  localparam int HI_W  = PAY_W - 32;
  localparam logic [PAY_W-1:0]  BLK_P = PAY_W'(BLK_BYTES);
  localparam logic [AUTH_W-1:0] BLK_A = AUTH_W'(BLK_BYTES);
  localparam logic [CNT_W-1:0]  BLK_C = CNT_W'(BLK_BYTES);

  logic [31:0]       lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [PAY_W-1:0]  pay_q, pay_nxt, new_pay;
  logic [AUTH_W-1:0] auth_q, auth_nxt;
  logic [J_W-1:0]    j_q;
  logic busy, endless_q, out_full, saved_q, start_q, done_q;

  wire idle     = !busy && !saved_q;
  wire combined = (mode_sel == 2'd1);
  wire tweaked  = (mode_sel == 2'd2);
  wire wr_lo    = host_we && idle && host_addr == 2'd0;
  wire wr_hi    = host_we && idle && host_addr == 2'd1;
  wire wr_auth  = host_we && idle && host_addr == 2'd2;
  wire go_basic = wr_hi && !combined;
  wire go_comb  = wr_auth && combined &&
                  (({hi_q, lo_q} != '0) || (host_wdata[AUTH_W-1:0] != '0));
  wire go       = go_basic || go_comb;
  wire take     = blk_go && busy && !out_full;

  assign new_pay  = go_comb ? {hi_q, lo_q} : {host_wdata[HI_W-1:0], lo_q};
  assign pay_nxt  = (pay_q >= BLK_P) ? pay_q - BLK_P : '0;
  assign auth_nxt = (auth_q >= BLK_A) ? auth_q - BLK_A : '0;
  assign auth_phase = busy && (auth_q != '0);

  wire fin = take && (auth_phase ? (auth_nxt == '0 && pay_q == '0)
                                 : (!endless_q && pay_nxt == '0));

  always_comb begin
    if (!busy)              cur_bytes = '0;
    else if (auth_phase)    cur_bytes = (auth_q >= BLK_A) ? BLK_C : auth_q[CNT_W-1:0];
    else if (endless_q)     cur_bytes = BLK_C;
    else                    cur_bytes = (pay_q >= BLK_P) ? BLK_C : pay_q[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0; hi_q <= '0; pay_q <= '0; auth_q <= '0; j_q <= '0;
      busy <= 1'b0; endless_q <= 1'b0; out_full <= 1'b0; saved_q <= 1'b0;
      start_q <= 1'b0; done_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      if (wr_lo) lo_q <= host_wdata;
      if (wr_hi) hi_q <= host_wdata[HI_W-1:0];
      if (wr_auth && tweaked) j_q <= host_wdata[31 -: J_W];
      if (go) begin
        busy      <= 1'b1;
        start_q   <= 1'b1;
        pay_q     <= new_pay;
        auth_q    <= go_comb ? host_wdata[AUTH_W-1:0] : '0;
        endless_q <= !combined && (new_pay == '0);
      end
      if (out_ack) out_full <= 1'b0;
      if (take) begin
        out_full <= 1'b1;
        if (auth_phase)      auth_q <= auth_nxt;
        else if (!endless_q) pay_q  <= pay_nxt;
        if (fin) begin
          busy    <= 1'b0;
          done_q  <= 1'b1;
          saved_q <= save_ctx_en;
        end
      end
      if (saved_ack) saved_q <= 1'b0;
    end
  end

  assign start        = start_q;
  assign done         = done_q;
  assign pay_rem      = pay_q;
  assign auth_rem     = auth_q;
  assign xts_j        = j_q;
  assign endless      = busy && endless_q;
  assign ctx_ready    = idle;
  assign saved_ready  = saved_q;
  assign input_ready  = busy && !out_full;
  assign output_ready = out_full;
  assign host_rdata   = (host_re && host_addr == 2'd3)
                        ? {28'b0, ctx_ready, saved_ready, input_ready, output_ready}
                        : 32'b0;

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctx_ready && saved_ready));
  // R11
  saved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(saved_ready) |-> $past(save_ctx_en));
  // R5
  pay_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (pay_rem <= $past(pay_rem)));
  // R7
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pay_rem == '0 && auth_rem == '0 && !input_ready));
  // R8
  endless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    endless |=> !done);
  // R12
  io_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(input_ready && output_ready));
  // R2
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(input_ready) && !$past(output_ready) |-> $past(start) || start);
endmodule

// File: tb/crypto_len_ctrl_bench.sv
module crypto_len_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 0;
  logic save_ctx_en = 0, host_we = 0, host_re = 0;
  logic [1:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic blk_go = 0, out_ack = 0, saved_ack = 0;
  logic start, done, auth_phase, endless, ctx_ready, saved_ready, input_ready, output_ready;
  logic [60:0] pay_rem;
  logic [31:0] auth_rem;
  logic [4:0] cur_bytes;
  logic [27:0] xts_j;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  crypto_len_ctrl u_crypto_len_ctrl (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    host_we = 0; host_re = 0; blk_go = 0; out_ack = 0; saved_ack = 0; save_ctx_en = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic blk();
    @(negedge clk); blk_go = 1;
    @(negedge clk); blk_go = 0;
  endtask

  task automatic ack();
    @(negedge clk); out_ack = 1;
    @(negedge clk); out_ack = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); host_re = 1; host_addr = a;
    #1 d = host_rdata;
    host_re = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ctx_ready", ctx_ready, 1);
    chk("R1 saved", saved_ready, 0);
    chk("R1 in/out", {input_ready, output_ready}, 0);
    chk("R1 start/done", {start, done}, 0);
    chk("R1 counts", {pay_rem, auth_rem}, 0);
  endtask

  task automatic t_hiword();
    do_reset(); mode_sel = 0;
    wr(0, 32'h20);
    chk("R2 low no start", {start, input_ready}, 0);
    wr(1, 32'hE000_0001);
    chk("R2 start", start, 1);
    chk("R2 pay", pay_rem, 64'h1_0000_0020);
  endtask

  task automatic t_basic();
    do_reset(); mode_sel = 0;
    wr(0, 40); wr(1, 0);
    chk("R2 pay", pay_rem, 40);
    chk("R5 cur16", cur_bytes, 16);
    blk();
    chk("R5 pay24", pay_rem, 24);
    chk("R12 out set", {input_ready, output_ready}, 2'b01);
    blk();
    chk("R12 ignored", pay_rem, 24);
    ack();
    chk("R12 in again", {input_ready, output_ready}, 2'b10);
    blk(); ack();
    chk("R5 pay8", pay_rem, 8);
    chk("R5 cur8", cur_bytes, 8);
    blk();
    chk("R7 done", done, 1);
    chk("R5 pay0", pay_rem, 0);
    chk("R7 ctx_ready", ctx_ready, 1);
    @(negedge clk);
    chk("R7 done pulse", done, 0);
    ack();
  endtask

  task automatic t_read();
    logic [31:0] d;
    do_reset(); mode_sel = 0;
    wr(0, 32'h1234); wr(2, 32'h55);
    rd(0, d); chk("R9 rd0", d, 0);
    rd(1, d); chk("R9 rd1", d, 0);
    rd(2, d); chk("R9 rd2", d, 0);
    rd(3, d); chk("R9 status idle", d, 32'h8);
    wr(1, 0);
    rd(3, d); chk("R9 status run", d, 32'h2);
  endtask

  task automatic t_comb();
    do_reset(); mode_sel = 1;
    wr(0, 20); wr(1, 0);
    chk("R3 hi no start", {start, input_ready, ctx_ready}, 3'b001);
    wr(2, 20);
    chk("R3 start", start, 1);
    chk("R3 auth", auth_rem, 20);
    chk("R3 pay", pay_rem, 20);
    chk("R6 phase", auth_phase, 1);
    blk(); ack();
    chk("R6 auth4", {auth_rem, pay_rem}, {32'd4, 61'd20});
    chk("R5 cur4", cur_bytes, 4);
    blk(); ack();
    chk("R6 auth0", {auth_rem, pay_rem}, {32'd0, 61'd20});
    chk("R6 phase off", auth_phase, 0);
    blk(); ack();
    chk("R6 pay4", pay_rem, 4);
    blk();
    chk("R7 done comb", done, 1);
  endtask

  task automatic t_comb_zero();
    do_reset(); mode_sel = 1;
    wr(0, 0); wr(1, 0); wr(2, 0);
    chk("R4 no start", {start, input_ready, ctx_ready}, 3'b001);
    wr(2, 16);
    chk("R4 auth only start", start, 1);
    blk();
    chk("R4 auth only done", done, 1);
  endtask

  task automatic t_endless();
    do_reset(); mode_sel = 0;
    wr(0, 0); wr(1, 0);
    chk("R8 start", start, 1);
    chk("R8 endless", endless, 1);
    chk("R8 cur16", cur_bytes, 16);
    for (int i = 0; i < 3; i++) begin
      blk();
      chk("R8 no done", done, 0);
      ack();
    end
    chk("R8 still running", {input_ready, endless}, 2'b11);
  endtask

  task automatic t_xts();
    do_reset(); mode_sel = 2;
    wr(2, 32'hABCD_EF57);
    chk("R10 j", xts_j, 28'hABCDEF5);
    chk("R10 no start", {start, input_ready}, 0);
    wr(0, 16); wr(1, 0);
    chk("R10 start hi", start, 1);
    chk("R10 pay", pay_rem, 16);
  endtask

  task automatic t_save();
    do_reset(); mode_sel = 0; save_ctx_en = 1;
    wr(0, 16); wr(1, 0);
    blk();
    chk("R11 saved", {saved_ready, ctx_ready}, 2'b10);
    ack();
    wr(0, 64); wr(1, 0);
    chk("R13 blocked while saved", {start, input_ready}, 0);
    @(negedge clk); saved_ack = 1;
    @(negedge clk); saved_ack = 0;
    chk("R11 cleared", {saved_ready, ctx_ready}, 2'b01);
  endtask

  task automatic t_busy();
    do_reset(); mode_sel = 0;
    wr(0, 48); wr(1, 0);
    wr(0, 5); wr(1, 0);
    chk("R13 pay kept", pay_rem, 48);
    chk("R13 no restart", start, 0);
  endtask

  initial begin
    t_reset(); t_hiword(); t_basic(); t_read(); t_comb();
    t_comb_zero(); t_endless(); t_xts(); t_save(); t_busy();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule